// File: doc/BRIEF.md
# Display memory time-slot scheduler

This block decides, one memory cycle at a time, what the single external display memory port does next. The port runs a 500 ns cycle, which gives 2 MB/s to share. Two cycles make up each microsecond. The users of the port are:

- loads of the internal character-row buffer,
- reads of user-defined character slices,
- indirect host reads and writes,
- DRAM refresh reads.

The sharing is a fixed time-division pattern chosen only by the current scan position. There is no priority arbitration.

The timing generator supplies the scan line number and a column counter. The column counter counts memory cycles within the line; bit 0 selects the first or second cycle of the microsecond. The schedule depends on the kind of line:

- **Blanking lines:** a refresh read followed by a host slot.
- **Ordinary active lines:** a slice read inside the display window (a refresh read outside it), followed by a host slot.
- **Load lines:** these are the first and last scan line of each ten-line character row. Their second cycles carry row-buffer loads, 60 per line, 120 per row. The host gets no slot at all on these lines.

A host request waits for the next host slot and is answered with a one-cycle acknowledge. A host slot with nothing pending becomes a dummy read. Refresh costs no extra cycles: it takes slots that would otherwise be idle. It draws its low address byte from an 8-bit counter that steps once per refresh cycle.

Top module: `memslot_sched`

## Requirements
- R1: While reset is asserted, and on the first cycles after it, the outputs are slot_o = 0, host_ack_o = 0 and rfsh_addr_o = 0. The slot codes are: 0 dummy, 1 refresh, 2 slice, 3 load, 4 host.
- R2: On a blanking line, that is a line outside [FIRST_ACTIVE, FIRST_ACTIVE + ROWS*ROW_LINES), the slot depends on col_i[0]. An even column gives refresh (1). An odd column gives host (4) when a request is pending, else dummy (0).
- R3: On an active line that is not a load line, even columns are handled as follows. A column in [WIN_START, WIN_START + WIN_LEN) gives slice (2); any other even column gives refresh (1). Odd columns are host slots, decided as in R2.
- R4: A load line is an active line whose offset from FIRST_ACTIVE, modulo ROW_LINES, is 0 or ROW_LINES-1. On such a line, even columns follow R3. An odd column gives load (3) when col_i/2 < LOAD_PER_LINE, else dummy (0). Host (4) and host_ack_o never occur for a load line.
- R5: A pulse on host_req_i stays pending until the next host slot. That slot is reported as host (4) with host_ack_o high for exactly that one cycle. Several requests made before the grant merge into a single grant.
- R6: rfsh_addr_o is 0 after reset. On each refresh slot it shows the counter value, which then advances by 1 modulo 256. Other slots leave the counter and rfsh_addr_o unchanged.
- R7: slot_o, host_ack_o and rfsh_addr_o reflect line_i, col_i and host_req_i of the previous clock cycle.
- R8: A request that arrives in the same cycle as a host slot is granted in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-cycle clock, one edge per 500 ns cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | LINE_W | Current scan line from the timing generator |
| col_i | input | COL_W | Memory-cycle index within the line; bit 0 is the microsecond phase |
| host_req_i | input | 1 | Host access request pulse |
| slot_o | output | 3 | Type of the memory cycle being issued |
| rfsh_addr_o | output | RFSH_W | Low address byte of the current or last refresh cycle |
| host_ack_o | output | 1 | One-cycle grant of a host access |

## Verification
The bench uses the default parameters: 25 rows of 10 lines starting at line 40, 128 cycles per line, an 80-cycle window from cycle 24, and 60 loads per line. It walks a complete 312-line frame in scan order. This brings within reach:

- every line kind and window edge,
- the transition from a row's last load line into the next row's first one,
- several full wraps of the refresh counter.

Seeded random request pulses and random scan jumps are added, along with directed requests placed on load lines. These show that grants are deferred and merged.

// File: rtl/memslot_pkg.sv
package memslot_pkg;

  typedef enum logic [2:0] {
    SLOT_DUMMY   = 3'd0,
    SLOT_REFRESH = 3'd1,
    SLOT_SLICE   = 3'd2,
    SLOT_LOAD    = 3'd3,
    SLOT_HOST    = 3'd4
  } slot_e;

  typedef enum logic [1:0] {
    LN_BLANK  = 2'd0,
    LN_ACTIVE = 2'd1,
    LN_LOAD   = 2'd2
  } line_kind_e;

endpackage

// File: rtl/memslot_line_class.sv
module memslot_line_class
  import memslot_pkg::*;
#(
  parameter int LINE_W       = 9,
  parameter int FIRST_ACTIVE = 40,
  parameter int ROWS         = 25,
  parameter int ROW_LINES    = 10
) (
  input  logic [LINE_W-1:0] line_i,
  output line_kind_e        kind_o
);

  localparam int LAST_ACTIVE = FIRST_ACTIVE + ROWS * ROW_LINES;

  logic [LINE_W-1:0] offs;
  logic [LINE_W-1:0] row_line;
  logic              in_area;

  always_comb begin
    offs     = line_i - LINE_W'(FIRST_ACTIVE);
    row_line = offs % LINE_W'(ROW_LINES);
    in_area  = (int'(line_i) >= FIRST_ACTIVE) && (int'(line_i) < LAST_ACTIVE);
    if (!in_area) begin
      kind_o = LN_BLANK;
    end else if ((row_line == '0) || (int'(row_line) == ROW_LINES - 1)) begin
      kind_o = LN_LOAD;
    end else begin
      kind_o = LN_ACTIVE;
    end
  end

endmodule

// File: rtl/memslot_pick.sv
module memslot_pick
  import memslot_pkg::*;
#(
  parameter int COL_W         = 7,
  parameter int WIN_START     = 24,
  parameter int WIN_LEN       = 80,
  parameter int LOAD_PER_LINE = 60
) (
  input  line_kind_e       kind_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             host_want_i,
  output slot_e            slot_o,
  output logic             grant_o
);

  localparam int WIN_END = WIN_START + WIN_LEN;

  logic             second_half;
  logic [COL_W-2:0] pair_idx;
  logic             in_win;
  slot_e            first_slot;

  always_comb begin
    second_half = col_i[0];
    pair_idx    = col_i[COL_W-1:1];
    in_win      = (int'(col_i) >= WIN_START) && (int'(col_i) < WIN_END);

    if ((kind_i != LN_BLANK) && in_win) begin
      first_slot = SLOT_SLICE;
    end else begin
      first_slot = SLOT_REFRESH;
    end

    if (!second_half) begin
      slot_o = first_slot;
    end else if (kind_i == LN_LOAD) begin
      slot_o = (int'(pair_idx) < LOAD_PER_LINE) ? SLOT_LOAD : SLOT_DUMMY;
    end else begin
      slot_o = host_want_i ? SLOT_HOST : SLOT_DUMMY;
    end

    grant_o = (slot_o == SLOT_HOST);
  end

endmodule

// File: rtl/memslot_host_gate.sv
module memslot_host_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic grant_i,
  output logic want_o,
  output logic ack_o
);

  logic pend_q, pend_d;
  logic ack_q;

  always_comb begin
    want_o = pend_q | req_i;
    pend_d = want_o & ~grant_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ack_q  <= grant_i;
    end
  end

  assign ack_o = ack_q;

  a_r5_grant_clears: assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |=> !pend_q);
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !grant_i) |=> pend_q);
  a_r8_no_grant_unwanted: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !req_i) |-> !grant_i);

endmodule

// File: rtl/memslot_rfsh.sv
module memslot_rfsh #(
  parameter int RFSH_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  output logic [RFSH_W-1:0] addr_o
);

  logic [RFSH_W-1:0] cnt_q, cnt_d;
  logic [RFSH_W-1:0] addr_q, addr_d;

  always_comb begin
    cnt_d  = cnt_q;
    addr_d = addr_q;
    if (step_i) begin
      addr_d = cnt_q;
      cnt_d  = cnt_q + RFSH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (step_i) begin
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

  a_r6_step_once: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (cnt_q == $past(cnt_q) + RFSH_W'(1)));
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(cnt_q) && $stable(addr_q));

endmodule

// File: rtl/memslot_sched.sv
module memslot_sched
  import memslot_pkg::*;
#(
  parameter int LINE_W        = 9,
  parameter int COL_W         = 7,
  parameter int FIRST_ACTIVE  = 40,
  parameter int ROWS          = 25,
  parameter int ROW_LINES     = 10,
  parameter int WIN_START     = 24,
  parameter int WIN_LEN       = 80,
  parameter int LOAD_PER_LINE = 60,
  parameter int RFSH_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] line_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              host_req_i,
  output logic [2:0]        slot_o,
  output logic [RFSH_W-1:0] rfsh_addr_o,
  output logic              host_ack_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  line_kind_e kind;
  slot_e      slot_d;
  slot_e      slot_q;
  logic       want;
  logic       grant;
  logic       rfsh_step;

  memslot_line_class #(
    .LINE_W(LINE_W), .FIRST_ACTIVE(FIRST_ACTIVE),
    .ROWS(ROWS), .ROW_LINES(ROW_LINES)
  ) u_class (
    .line_i (line_i),
    .kind_o (kind)
  );

  memslot_pick #(
    .COL_W(COL_W), .WIN_START(WIN_START),
    .WIN_LEN(WIN_LEN), .LOAD_PER_LINE(LOAD_PER_LINE)
  ) u_pick (
    .kind_i      (kind),
    .col_i       (col_i),
    .host_want_i (want),
    .slot_o      (slot_d),
    .grant_o     (grant)
  );

  memslot_host_gate u_host (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .req_i   (host_req_i),
    .grant_i (grant),
    .want_o  (want),
    .ack_o   (host_ack_o)
  );

  assign rfsh_step = (slot_d == SLOT_REFRESH);

  memslot_rfsh #(.RFSH_W(RFSH_W)) u_rfsh (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .step_i (rfsh_step),
    .addr_o (rfsh_addr_o)
  );

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      slot_q <= SLOT_DUMMY;
    end else begin
      slot_q <= slot_d;
    end
  end

  assign slot_o = slot_q;

  a_r5_ack_matches_host: assert property (@(posedge clk) disable iff (!rst_sync_q)
    host_ack_o == (slot_o == SLOT_HOST));
  a_r2_refresh_first_half: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (slot_d == SLOT_REFRESH) |-> !col_i[0]);
  a_r4_load_second_half: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (slot_d == SLOT_LOAD) |-> col_i[0]);
  a_r4_no_grant_on_load: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (kind == LN_LOAD) |-> !grant);
  a_r3_slice_only_active: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (slot_d == SLOT_SLICE) |-> (kind != LN_BLANK));

endmodule

// File: tb/memslot_sched_tb.sv
`timescale 1ns/1ps
module memslot_sched_tb;

  localparam int CLK_PERIOD  = 500;
  localparam int FRAME_LINES = 312;
  localparam int FIRST_ACT   = 40;
  localparam int ROWS        = 25;
  localparam int ROW_LINES   = 10;
  localparam int WIN_START   = 24;
  localparam int WIN_LEN     = 80;
  localparam int LOADS       = 60;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] line_i;
  logic [6:0] col_i;
  logic       host_req_i;
  logic [2:0] slot_o;
  logic [7:0] rfsh_addr_o;
  logic       host_ack_o;

  int checks = 0;
  int errors = 0;
  bit pend   = 1'b0;
  int rcnt   = 0;
  int raddr  = 0;
  int acks   = 0;

  memslot_sched u_dut (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .col_i(col_i),
    .host_req_i(host_req_i), .slot_o(slot_o),
    .rfsh_addr_o(rfsh_addr_o), .host_ack_o(host_ack_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // 0 blank, 1 active, 2 load
  function automatic int kind_of(int ln);
    if (ln < FIRST_ACT || ln >= FIRST_ACT + ROWS*ROW_LINES) return 0;
    if (((ln - FIRST_ACT) % ROW_LINES) == 0 ||
        ((ln - FIRST_ACT) % ROW_LINES) == ROW_LINES-1) return 2;
    return 1;
  endfunction

  function automatic int exp_slot(int ln, int cl, bit want);
    int k = kind_of(ln);
    if ((cl % 2) == 0) begin
      if (k != 0 && cl >= WIN_START && cl < WIN_START + WIN_LEN) return 2;
      return 1;
    end
    if (k == 2) return ((cl / 2) < LOADS) ? 3 : 0;
    return want ? 4 : 0;
  endfunction

  function automatic string tag_of(int ln);
    int k = kind_of(ln);
    return (k == 0) ? "R2" : (k == 1) ? "R3" : "R4";
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R7: inputs applied now appear at the outputs after the next edge
  task automatic step(int ln, int cl, bit rq);
    bit want;
    int es;
    line_i = 9'(ln); col_i = 7'(cl); host_req_i = rq;
    @(posedge clk); #1;
    want = pend | rq;
    es = exp_slot(ln, cl, want);
    if (es == 1) begin
      raddr = rcnt;
      rcnt = (rcnt + 1) % 256;
    end
    chk(int'(slot_o) == es, tag_of(ln), int'(slot_o), es);
    chk(host_ack_o == (es == 4), (rq && !pend) ? "R8" : "R5", int'(host_ack_o), int'(es == 4));
    chk(int'(rfsh_addr_o) == raddr, "R6", int'(rfsh_addr_o), raddr);
    if (es == 4) acks++;
    pend = want && (es != 4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; line_i = '0; col_i = 7'd1; host_req_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(slot_o == 3'd0, "R1", int'(slot_o), 0);
    chk(host_ack_o == 1'b0, "R1", int'(host_ack_o), 0);
    chk(rfsh_addr_o == 8'd0, "R1", int'(rfsh_addr_o), 0);
    // idle on an odd blank column: dummy, no state change
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(slot_o == 3'd0, "R1", int'(slot_o), 0);
    chk(rfsh_addr_o == 8'd0, "R1", int'(rfsh_addr_o), 0);

    // directed R5: two requests on a load line merge into one grant
    step(40, 0, 1'b1);
    step(40, 1, 1'b0);
    step(40, 2, 1'b1);
    a0 = acks;
    for (int c = 3; c < 128; c++) step(40, c, 1'b0);
    chk(acks == a0, "R4", acks, a0);
    step(41, 0, 1'b0);
    step(41, 1, 1'b0);
    chk(acks == a0 + 1, "R5", acks, a0 + 1);
    step(41, 2, 1'b0);
    step(41, 3, 1'b0);
    chk(acks == a0 + 1, "R5", acks, a0 + 1);

    // directed R8: request in the host slot itself
    step(5, 7, 1'b1);

    // full frame in scan order with random request pulses
    for (int ln = 0; ln < FRAME_LINES; ln++)
      for (int c = 0; c < 128; c++)
        step(ln, c, ($urandom % 6) == 0);

    // random scan jumps
    for (int i = 0; i < 3000; i++)
      step(int'($urandom % FRAME_LINES), int'($urandom % 128), ($urandom % 4) == 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule